// File: doc/BRIEF.md
# Data Access Fault Checker

This block sits beside the load/store stage of a processor pipeline and examines every data access as it is issued. It detects three kinds of fault: an address that is not a multiple of the access size, an address outside the permitted stack window, and an access that the bus fabric reports as landing in an unassigned region. When a fault is seen it records the faulting address and builds a status word that tells software what happened. It also issues a one-cycle request for a hardware exception, following separate enable rules for each fault kind.

The status word has a cause code in bits 4:0. For alignment faults it also carries the destination register index, the direction of the access and whether the access was word-sized, so a trap handler can emulate the access. Only one fault is reported per access. When several conditions hold in the same cycle, an alignment fault wins over a stack fault, and a stack fault wins over an unassigned-region fault.

Top module: `acc_fault_guard`

## Requirements
- R1: An access presented with `accValid` high is misaligned when `accAddr[1:0] & sizeMask` is non-zero. `sizeMask` is 0 for byte, 1 for halfword and 3 for word accesses, so a byte access is never misaligned.
- R2: On a misaligned access the status word becomes: cause 5'h01 in bits 4:0, `dstReg` in bits 9:5, `isWrite` in bit 10, and zero above bit 11.
- R3: Bit 11 of a misalignment status word is 1 exactly when `sizeMask` is 3.
- R4: A misaligned access always loads `faultAddr` and `faultStatus`. An exception is requested only when `excEnable` is 1.
- R5: An aligned access is a stack violation when `accAddr < stackLo` or `accAddr > stackHi`. Addresses equal to either bound are legal.
- R6: A stack violation loads `faultAddr` and sets the status word to cause 5'h07 with all other bits zero. It requests an exception whatever the value of `excEnable`.
- R7: An unassigned-region access (`unassigned` = 1) with no other fault and `excEnable` = 0 changes neither register and requests no exception.
- R8: An unassigned-region access with `excEnable` = 1 loads `faultAddr`. If `fetchSide` = 1 and `iBusExcEn` = 1, the status becomes 5'h03 and an exception is requested. If `fetchSide` = 0 and `dBusExcEn` = 1, the status becomes 5'h04 and an exception is requested. Otherwise the status holds and no exception is requested.
- R9: When conditions coincide, misalignment takes priority over a stack violation, which takes priority over an unassigned-region access.
- R10: Without a fault, including every cycle with `accValid` = 0, `faultAddr` and `faultStatus` hold their values. After reset both are zero.
- R11: `excReq` is registered. It is high only in the cycle after an access that requested an exception, and it is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | A data access is presented this cycle |
| accAddr | input | ADDR_W | Access address |
| sizeMask | input | 2 | Alignment mask: 0 byte, 1 halfword, 3 word |
| isWrite | input | 1 | Access is a store |
| dstReg | input | 5 | Destination/source register index |
| stackLo | input | ADDR_W | Lowest legal stack address (inclusive) |
| stackHi | input | ADDR_W | Highest legal stack address (inclusive) |
| unassigned | input | 1 | Bus reports the access hit an unassigned region |
| fetchSide | input | 1 | 1: instruction-side access, 0: data-side |
| excEnable | input | 1 | Global exception enable |
| iBusExcEn | input | 1 | Instruction-bus error exceptions configured |
| dBusExcEn | input | 1 | Data-bus error exceptions configured |
| faultAddr | output | ADDR_W | Captured faulting address |
| faultStatus | output | 32 | Exception status word |
| excReq | output | 1 | One-cycle hardware exception request |

## Verification
The assertions assume that `sizeMask` only takes the values 0, 1 and 3, and that `stackLo` is never above `stackHi` while accesses are presented. The random stimulus draws the size from those three codes only. It builds the stack window by ordering two random values, or by using a wide fixed window, so the inputs stay within these assumptions. Directed cases then cover the exact bounds, the overlap of all three fault kinds, and the no-effect cases.

// File: rtl/acc_fault_pkg.sv
package acc_fault_pkg;
  localparam int CAUSE_W = 5;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_ALIGN = 5'h01,
    CAUSE_IBUS  = 5'h03,
    CAUSE_DBUS  = 5'h04,
    CAUSE_STACK = 5'h07
  } cause_e;

  typedef enum logic [1:0] {
    SEL_ALIGN = 2'd0,
    SEL_STACK = 2'd1,
    SEL_IBUS  = 2'd2,
    SEL_DBUS  = 2'd3
  } statSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     capAddr;
    logic     loadStatus;
    statSel_e statSel;
  } strobe_t;
endpackage

// File: rtl/acc_fault_dp.sv
module acc_fault_dp
  import acc_fault_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 5,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [1:0]        sizeMask,
  input  logic              isWrite,
  input  logic [REG_W-1:0]  dstReg,
  input  logic [ADDR_W-1:0] stackLo,
  input  logic [ADDR_W-1:0] stackHi,
  input  strobe_t           strobes,
  output logic              misaligned,
  output logic              stackViol,
  output logic [ADDR_W-1:0] faultAddr,
  output logic [STAT_W-1:0] faultStatus
);
  localparam int WR_BIT   = CAUSE_W + REG_W;
  localparam int WORD_BIT = WR_BIT + 1;
  localparam int PAD_W    = STAT_W - WORD_BIT - 1;

  logic              wordSized;
  logic              belowLo;
  logic              aboveHi;
  logic [STAT_W-1:0] alignWord;
  logic [STAT_W-1:0] nextStatus;

  // detection
  assign misaligned = |(accAddr[1:0] & sizeMask);
  assign wordSized  = (sizeMask == 2'b11);
  assign belowLo    = (accAddr < stackLo);
  assign aboveHi    = (accAddr > stackHi);
  assign stackViol  = belowLo | aboveHi;

  // status word assembly
  assign alignWord = {{PAD_W{1'b0}}, wordSized, isWrite, dstReg, CAUSE_ALIGN};

  always_comb begin
    unique case (strobes.statSel)
      SEL_ALIGN: nextStatus = alignWord;
      SEL_STACK: nextStatus = {{(STAT_W-CAUSE_W){1'b0}}, CAUSE_STACK};
      SEL_IBUS:  nextStatus = {{(STAT_W-CAUSE_W){1'b0}}, CAUSE_IBUS};
      SEL_DBUS:  nextStatus = {{(STAT_W-CAUSE_W){1'b0}}, CAUSE_DBUS};
      default:   nextStatus = faultStatus;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      faultAddr <= '0;
    end else if (strobes.capAddr) begin
      faultAddr <= accAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      faultStatus <= '0;
    end else if (strobes.loadStatus) begin
      faultStatus <= nextStatus;
    end
  end
endmodule

// File: rtl/acc_fault_ctrl.sv
module acc_fault_ctrl
  import acc_fault_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    accValid,
  input  logic    misaligned,
  input  logic    stackViol,
  input  logic    unassigned,
  input  logic    fetchSide,
  input  logic    excEnable,
  input  logic    iBusExcEn,
  input  logic    dBusExcEn,
  output strobe_t strobes,
  output logic    excReq
);
  logic raiseNext;
  logic busCfgHit;

  assign busCfgHit = fetchSide ? iBusExcEn : dBusExcEn;

  // fixed priority: alignment, stack window, unassigned region
  always_comb begin
    strobes   = '{capAddr: 1'b0, loadStatus: 1'b0, statSel: SEL_ALIGN};
    raiseNext = 1'b0;
    if (accValid) begin
      if (misaligned) begin
        strobes.capAddr    = 1'b1;
        strobes.loadStatus = 1'b1;
        strobes.statSel    = SEL_ALIGN;
        raiseNext          = excEnable;
      end else if (stackViol) begin
        strobes.capAddr    = 1'b1;
        strobes.loadStatus = 1'b1;
        strobes.statSel    = SEL_STACK;
        raiseNext          = 1'b1;
      end else if (unassigned && excEnable) begin
        strobes.capAddr = 1'b1;
        if (busCfgHit) begin
          strobes.loadStatus = 1'b1;
          strobes.statSel    = fetchSide ? SEL_IBUS : SEL_DBUS;
          raiseNext          = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      excReq <= 1'b0;
    end else begin
      excReq <= raiseNext;
    end
  end
endmodule

// File: rtl/acc_fault_guard.sv
module acc_fault_guard
  import acc_fault_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [1:0]        sizeMask,
  input  logic              isWrite,
  input  logic [4:0]        dstReg,
  input  logic [ADDR_W-1:0] stackLo,
  input  logic [ADDR_W-1:0] stackHi,
  input  logic              unassigned,
  input  logic              fetchSide,
  input  logic              excEnable,
  input  logic              iBusExcEn,
  input  logic              dBusExcEn,
  output logic [ADDR_W-1:0] faultAddr,
  output logic [31:0]       faultStatus,
  output logic              excReq
);
  strobe_t strobes;
  logic    misaligned;
  logic    stackViol;

  acc_fault_dp #(.ADDR_W(ADDR_W), .REG_W(5), .STAT_W(32)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .accAddr    (accAddr),
    .sizeMask   (sizeMask),
    .isWrite    (isWrite),
    .dstReg     (dstReg),
    .stackLo    (stackLo),
    .stackHi    (stackHi),
    .strobes    (strobes),
    .misaligned (misaligned),
    .stackViol  (stackViol),
    .faultAddr  (faultAddr),
    .faultStatus(faultStatus)
  );

  acc_fault_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .accValid  (accValid),
    .misaligned(misaligned),
    .stackViol (stackViol),
    .unassigned(unassigned),
    .fetchSide (fetchSide),
    .excEnable (excEnable),
    .iBusExcEn (iBusExcEn),
    .dBusExcEn (dBusExcEn),
    .strobes   (strobes),
    .excReq    (excReq)
  );
endmodule

// File: rtl/acc_fault_guard_chk.sv
module acc_fault_guard_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accValid,
  input logic [ADDR_W-1:0] accAddr,
  input logic [1:0]        sizeMask,
  input logic [ADDR_W-1:0] stackLo,
  input logic [ADDR_W-1:0] stackHi,
  input logic              unassigned,
  input logic              excEnable,
  input logic [ADDR_W-1:0] faultAddr,
  input logic [31:0]       faultStatus,
  input logic              excReq
);
  logic misNow;
  logic outNow;
  assign misNow = accValid && ((accAddr[1:0] & sizeMask) != 2'b00);
  assign outNow = accValid && !misNow && ((accAddr < stackLo) || (accAddr > stackHi));

  // R4: alignment fault captures address and cause
  p_align_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    misNow |=> (faultAddr == $past(accAddr)) && (faultStatus[4:0] == 5'h01));

  // R4: alignment request follows global enable
  p_align_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    misNow |=> (excReq == $past(excEnable)));

  // R6: stack violation always raises with its cause
  p_stack_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    outNow |=> excReq && (faultStatus == 32'h7));

  // R7: disabled unassigned access leaves everything untouched
  p_unassigned_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && unassigned && !misNow && !outNow && !excEnable)
      |=> $stable(faultAddr) && $stable(faultStatus) && !excReq);

  // R10: idle cycles hold state; R11: no request without an access
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !accValid |=> $stable(faultAddr) && $stable(faultStatus) && !excReq);
endmodule

bind acc_fault_guard acc_fault_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accValid   (accValid),
  .accAddr    (accAddr),
  .sizeMask   (sizeMask),
  .stackLo    (stackLo),
  .stackHi    (stackHi),
  .unassigned (unassigned),
  .excEnable  (excEnable),
  .faultAddr  (faultAddr),
  .faultStatus(faultStatus),
  .excReq     (excReq)
);

// File: tb/acc_fault_guard_tb.sv
`timescale 1ns/1ps
module acc_fault_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic [1:0]  sizeMask = '0;
  logic        isWrite = 1'b0;
  logic [4:0]  dstReg = '0;
  logic [31:0] stackLo = 32'h0000_1000;
  logic [31:0] stackHi = 32'hFFFF_0000;
  logic        unassigned = 1'b0;
  logic        fetchSide = 1'b0;
  logic        excEnable = 1'b0;
  logic        iBusExcEn = 1'b0;
  logic        dBusExcEn = 1'b0;
  logic [31:0] faultAddr;
  logic [31:0] faultStatus;
  logic        excReq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [31:0] expAddr = '0;
  logic [31:0] expStat = '0;
  logic        expReq = 1'b0;

  always #10 clk = ~clk;

  acc_fault_guard u_dut (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .accAddr(accAddr),
    .sizeMask(sizeMask), .isWrite(isWrite), .dstReg(dstReg),
    .stackLo(stackLo), .stackHi(stackHi), .unassigned(unassigned),
    .fetchSide(fetchSide), .excEnable(excEnable), .iBusExcEn(iBusExcEn),
    .dBusExcEn(dBusExcEn), .faultAddr(faultAddr), .faultStatus(faultStatus),
    .excReq(excReq)
  );

  function automatic logic [31:0] alignStatus(logic [1:0] m, logic w, logic [4:0] r);
    return {20'b0, (m == 2'b11), w, r, 5'h01};
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // apply the current inputs for one cycle and check the registered result
  task automatic step(string tagIn);
    logic mis;
    logic outB;
    string tag;
    tag = tagIn;
    mis  = accValid && ((accAddr[1:0] & sizeMask) != 2'b00);
    outB = accValid && !mis && ((accAddr < stackLo) || (accAddr > stackHi));
    expReq = 1'b0;
    if (mis) begin
      expAddr = accAddr;
      expStat = alignStatus(sizeMask, isWrite, dstReg);
      expReq  = excEnable;
      if (tag == "") tag = "R2/R4";
    end else if (outB) begin
      expAddr = accAddr;
      expStat = 32'h7;
      expReq  = 1'b1;
      if (tag == "") tag = "R6";
    end else if (accValid && unassigned && excEnable) begin
      expAddr = accAddr;
      if (fetchSide ? iBusExcEn : dBusExcEn) begin
        expStat = fetchSide ? 32'h3 : 32'h4;
        expReq  = 1'b1;
      end
      if (tag == "") tag = "R8";
    end else if (tag == "") begin
      tag = "R10";
    end
    @(negedge clk);
    check(tag, "faultAddr", faultAddr, expAddr);
    check(tag, "faultStatus", faultStatus, expStat);
    check(tag, "excReq", {31'b0, excReq}, {31'b0, expReq});
  endtask

  task automatic access(logic [31:0] a, logic [1:0] m, logic w, logic [4:0] r,
                        logic un, logic fs, logic en, logic ib, logic db);
    accValid = 1'b1; accAddr = a; sizeMask = m; isWrite = w; dstReg = r;
    unassigned = un; fetchSide = fs; excEnable = en; iBusExcEn = ib; dBusExcEn = db;
  endtask

  initial begin : watchdog
    #(200000 * 20);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    int seedDummy;
    seedDummy = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    // R10 / R11: reset state
    check("R10", "reset faultAddr", faultAddr, 32'h0);
    check("R10", "reset faultStatus", faultStatus, 32'h0);
    check("R11", "reset excReq", {31'b0, excReq}, 32'h0);
    rst_n = 1'b1;

    // R1: byte access at odd address is legal
    access(32'h0000_2003, 2'd0, 1'b0, 5'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    step("R1");
    // R4: halfword misalign with enable clear captures but no request
    access(32'h0000_3001, 2'd1, 1'b0, 5'd9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R4");
    // R2 / R3: word store misalign, reg 17, enable set
    access(32'h0000_4002, 2'd3, 1'b1, 5'd17, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    step("R3");
    // R11: idle cycle drops the request, R10 holds
    accValid = 1'b0;
    step("R11");
    // R1: halfword at address ending in 2 is aligned
    access(32'h0000_5002, 2'd1, 1'b0, 5'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    step("R1");
    // R5: exact bounds are legal
    stackLo = 32'h0000_8000; stackHi = 32'h0000_9000;
    access(32'h0000_8000, 2'd3, 1'b0, 5'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    step("R5");
    access(32'h0000_9000, 2'd3, 1'b0, 5'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    step("R5");
    // R6: below low bound with enable clear still raises
    access(32'h0000_7FFC, 2'd3, 1'b0, 5'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R6");
    access(32'h0000_9004, 2'd3, 1'b1, 5'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R6");
    // R7: unassigned with enable clear has no effect
    access(32'h0000_8800, 2'd3, 1'b0, 5'd4, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    step("R7");
    // R8: data-side with config, instruction-side with config, data-side without
    access(32'h0000_8804, 2'd3, 1'b0, 5'd4, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    step("R8");
    access(32'h0000_8808, 2'd3, 1'b0, 5'd4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    step("R8");
    access(32'h0000_880C, 2'd3, 1'b0, 5'd4, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    step("R8");
    // R9: all three conditions: alignment wins
    access(32'h0000_0001, 2'd1, 1'b1, 5'd30, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    step("R9");
    // R9: stack over unassigned
    access(32'h0000_0010, 2'd3, 1'b0, 5'd30, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    step("R9");
    accValid = 1'b0;
    step("R10");

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      logic [31:0] b;
      int sz;
      accValid   = ($urandom_range(0, 9) < 8);
      sz         = $urandom_range(0, 2);
      sizeMask   = (sz == 0) ? 2'd0 : (sz == 1) ? 2'd1 : 2'd3;
      isWrite    = $urandom_range(0, 1);
      dstReg     = 5'($urandom_range(0, 31));
      unassigned = ($urandom_range(0, 3) == 0);
      fetchSide  = $urandom_range(0, 1);
      excEnable  = $urandom_range(0, 1);
      iBusExcEn  = $urandom_range(0, 1);
      dBusExcEn  = $urandom_range(0, 1);
      if ($urandom_range(0, 3) == 0) begin
        a = $urandom(); b = $urandom();
        stackLo = (a < b) ? a : b;
        stackHi = (a < b) ? b : a;
        accAddr = $urandom();
      end else begin
        stackLo = 32'h0000_1000;
        stackHi = 32'hFFFF_0000;
        accAddr = 32'h0000_1000 + ($urandom() & 32'h0FFF_FFFF);
      end
      step("");
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule